// File: doc/BRIEF.md
# Shared-Adder ALU with Control Decode

This block is the arithmetic unit of a small multi-cycle processor with 8-bit data, together with the decoder that chooses its operation. The main controller supplies a 2-bit operation class. The instruction supplies its 6-bit function field, which is bits 5:0 of the instruction word. The decoder turns these two inputs into a 3-bit control code. The datapath applies that code to two operands and returns the result and a zero flag.

Add, subtract and set-less-than all use one adder. Control bit 2 inverts the second operand and forces a carry-in of one, which turns the sum into a difference. Set-less-than does not use a comparator. It takes the sign bit of the adder output. The block is purely combinational. The controller samples the result in its own registers.

Top module: `alu_core`

## Requirements
- R1: Operation class 00 produces control code 3'b010 (add), whatever the function field holds.
- R2: Operation class 01 produces control code 3'b110 (subtract), whatever the function field holds.
- R3: Under operation class 10, these function codes select these control codes:
  - 6'b100000 gives 3'b010 (add).
  - 6'b100010 gives 3'b110 (subtract).
  - 6'b100100 gives 3'b000 (AND).
  - 6'b100101 gives 3'b001 (OR).
  - 6'b101010 gives 3'b111 (set-less-than).
- R4: Under operation class 10, any function code not listed in R3 gives 3'b010 (add).
- R5: Operation class 11 behaves as class 00 and produces 3'b010.
- R6: Control code 000 outputs the bitwise AND of the operands, and 001 outputs their bitwise OR.
- R7: Control code 010 outputs (a + b) mod 256.
- R8: Control code 110 outputs (a + ~b + 1) mod 256, which equals (a - b) mod 256.
- R9: Control code 111 outputs 8'h01 when bit 7 of (a - b) mod 256 is 1, and 8'h00 otherwise. This is the sign of the wrapped difference.
- R10: The zero output is 1 exactly when all result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opClass | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field, instruction bits 5:0 |
| srcA | input | 8 | First operand |
| srcB | input | 8 | Second operand |
| aluCtrl | output | 3 | Decoded control code |
| result | output | 8 | ALU result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench drives the carry edges of the shared adder: 0xFF + 0x01 must wrap to 0 with zero set, and 0x00 - 0x01 must give 0xFF. A design with a missing carry-in or a non-inverted operand gives a result that is off by one or has the wrong sign.

Set-less-than is tested with 0x80 against 0x01. The wrapped difference is 0x7F, so the result is 0. A design that does a true signed compare, or that reads bit 7 of the wrong signal, reports 1.

Function codes just outside the table check that they fall back to add. A decoder that matches only some of the bits maps them to AND or OR.

Class 01 is driven with a function code of AND. A decoder that ignores the operation class then loses branch compares.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int CtrlW = 3;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SLT = 2'b11
  } aluSel_e;

  typedef struct packed {
    logic    invB;
    aluSel_e sel;
  } aluStrobe_t;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [1:0] opClass,
  input  logic [5:0] funct,
  output aluStrobe_t strobe
);
  always_comb begin
    strobe = '{invB: 1'b0, sel: SEL_SUM};
    unique case (opClass)
      2'b01: strobe = '{invB: 1'b1, sel: SEL_SUM};
      2'b10: begin
        case (funct)
          FN_SUB:  strobe = '{invB: 1'b1, sel: SEL_SUM};
          FN_AND:  strobe = '{invB: 1'b0, sel: SEL_AND};
          FN_OR:   strobe = '{invB: 1'b0, sel: SEL_OR};
          FN_SLT:  strobe = '{invB: 1'b1, sel: SEL_SLT};
          default: strobe = '{invB: 1'b0, sel: SEL_SUM};
        endcase
      end
      default: strobe = '{invB: 1'b0, sel: SEL_SUM};
    endcase

    // Classes other than 10 never select a logic operation
    p_fixed_class_r1: assert (opClass == 2'b10 || strobe.sel == SEL_SUM);
    p_sub_class_r2: assert (opClass != 2'b01 || strobe.invB);
    // Set-less-than always subtracts
    p_slt_inverts_r3: assert (strobe.sel != SEL_SLT || strobe.invB);
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int MsbIdx = WIDTH - 1;

  logic [WIDTH-1:0] bOperand;
  logic [WIDTH-1:0] sum;

  always_comb begin
    bOperand = strobe.invB ? ~b : b;
    sum = a + bOperand + WIDTH'(strobe.invB);
    unique case (strobe.sel)
      SEL_AND: result = a & b;
      SEL_OR:  result = a | b;
      SEL_SUM: result = sum;
      default: result = {{MsbIdx{1'b0}}, sum[MsbIdx]};
    endcase
    zero = ~|result;

    p_add_r7: assert (strobe.sel != SEL_SUM || strobe.invB || result == WIDTH'(a + b));
    p_sub_r8: assert (strobe.sel != SEL_SUM || !strobe.invB || result == WIDTH'(a - b));
    p_slt_r9: assert (strobe.sel != SEL_SLT || result[MsbIdx:1] == '0);
    p_zero_r10: assert (zero == (result == '0));
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       opClass,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [CtrlW-1:0] aluCtrl,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  aluStrobe_t strobe;

  alu_decode u_decode (
    .opClass(opClass),
    .funct  (funct),
    .strobe (strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .strobe(strobe),
    .a     (srcA),
    .b     (srcB),
    .result(result),
    .zero  (zero)
  );

  assign aluCtrl = strobe;
endmodule

// File: tb/alu_core_bench.sv
module alu_core_bench;
  logic       clk = 1'b0;
  logic [1:0] opClass = 2'b00;
  logic [5:0] funct = 6'd0;
  logic [7:0] srcA = 8'd0;
  logic [7:0] srcB = 8'd0;
  logic [2:0] aluCtrl;
  logic [7:0] result;
  logic       zero;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_core u_alu_core (
    .opClass(opClass), .funct(funct), .srcA(srcA), .srcB(srcB),
    .aluCtrl(aluCtrl), .result(result), .zero(zero)
  );

  function automatic logic [2:0] refCtrl(input logic [1:0] cls, input logic [5:0] fn);
    if (cls == 2'b01) return 3'b110;
    if (cls != 2'b10) return 3'b010;
    case (fn)
      6'h22: return 3'b110;
      6'h24: return 3'b000;
      6'h25: return 3'b001;
      6'h2A: return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [7:0] refRes(input logic [2:0] c, input logic [7:0] a, input logic [7:0] b);
    int d;
    d = (int'(a) - int'(b)) & 255;
    case (c)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b010: return 8'((int'(a) + int'(b)) & 255);
      3'b110: return 8'(d);
      default: return (d >= 128) ? 8'h01 : 8'h00;
    endcase
  endfunction

  task automatic apply(input logic [1:0] cls, input logic [5:0] fn,
                       input logic [7:0] a, input logic [7:0] b, input string req);
    logic [2:0] ec;
    logic [7:0] er;
    @(posedge clk);
    opClass = cls; funct = fn; srcA = a; srcB = b;
    @(negedge clk);
    ec = refCtrl(cls, fn);
    er = refRes(ec, a, b);
    checks++;
    if (aluCtrl !== ec) begin
      fails++;
      $display("FAIL %s ctrl: got %b expected %b (cls=%b fn=%b)", req, aluCtrl, ec, cls, fn);
    end
    checks++;
    if (result !== er) begin
      fails++;
      $display("FAIL %s result: got %h expected %h (a=%h b=%h)", req, result, er, a, b);
    end
    checks++;
    if (zero !== (er == 8'h00)) begin
      fails++;
      $display("FAIL R10 zero: got %b expected %b (result %h)", zero, er == 8'h00, er);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    // Initial idle state: class 00 on zero operands
    apply(2'b00, 6'd0, 8'h00, 8'h00, "R1 idle");
    apply(2'b00, 6'h24, 8'h12, 8'h34, "R1");
    apply(2'b01, 6'h24, 8'h05, 8'h05, "R2");
    apply(2'b01, 6'h25, 8'h00, 8'h01, "R2 R8");
    apply(2'b10, 6'h20, 8'hFF, 8'h01, "R3 R7 wrap");
    apply(2'b10, 6'h22, 8'h10, 8'h20, "R3 R8");
    apply(2'b10, 6'h24, 8'hF0, 8'h3C, "R3 R6 and");
    apply(2'b10, 6'h25, 8'hF0, 8'h0F, "R3 R6 or");
    apply(2'b10, 6'h2A, 8'h80, 8'h01, "R3 R9 wrapped sign");
    apply(2'b10, 6'h2A, 8'h01, 8'h02, "R9 less");
    apply(2'b10, 6'h2A, 8'h05, 8'h05, "R9 equal");
    apply(2'b10, 6'h21, 8'h03, 8'h04, "R4");
    apply(2'b10, 6'h26, 8'h03, 8'h04, "R4");
    apply(2'b10, 6'h2B, 8'h03, 8'h04, "R4");
    apply(2'b10, 6'h04, 8'h03, 8'h04, "R4");
    apply(2'b11, 6'h22, 8'h7F, 8'h01, "R5");
    apply(2'b10, 6'h24, 8'hAA, 8'h55, "R6 R10 zero and");
    for (int i = 0; i < 400; i++) begin
      logic [1:0] cls;
      logic [5:0] fn;
      cls = 2'($urandom);
      case ($urandom % 6)
        0: fn = 6'h20;
        1: fn = 6'h22;
        2: fn = 6'h24;
        3: fn = 6'h25;
        4: fn = 6'h2A;
        default: fn = 6'($urandom);
      endcase
      apply(cls, fn, 8'($urandom), 8'($urandom), "R1-random R7 R8 R9");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule